// File: doc/BRIEF.md
# Prioritized Multi-Processor Interrupt Controller

This block gathers fifteen interrupt sources, numbered 1 to 15, and gives each of several processors a 4-bit request level. The level equals the number of the highest-numbered source that is both outstanding and enabled for that processor, so source number and priority are the same thing. A processor's trap number for a source is 0x10 plus the level, which places the traps at 0x11 through 0x1F.

There are two ways for a source to become outstanding. A rising edge on its input latches a shared pending bit, and software can set a bit in a separate force register. Software removes sources by writing ones to a clear register. Each processor also has an acknowledge port: when it accepts an interrupt, it returns the level it took, and that source's pending and force bits drop. Every processor has its own enable mask, while pending and force are shared by all processors.

Registers sit on a single-cycle word bus. Writes take effect at the clock edge, and read data is combinational while the select is high. The offsets are 0x04 for pending (read-only), 0x08 for force, 0x0C for clear (write-only, reads zero) and 0x40 + 4*c for the mask of processor c.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the pending, force and all mask registers read zero, and every processor's level is 0.
- R2: A rising edge on source input n (1..15) sets pending bit n at the next clock edge. A source input that stays high sets the bit again only after a new rising edge.
- R3: A pending bit stays set after its source input returns low, until it is cleared or acknowledged.
- R4: A write to 0x0C clears the pending and force bits wherever the written word has a one. Bits written as zero leave their sources unchanged.
- R5: A write to 0x08 sets the force bits where the word has ones. Reading 0x08 returns the force bits, and a forced source drives the level the same way a pending one does.
- R6: A write to 0x40 + 4*c sets the mask of processor c (bit n = 1 enables source n). It changes only that processor's level, and the mask can be read back at the same address.
- R7: A processor's level is the highest n for which (pending[n] OR force[n]) AND mask[n] holds, and 0 when no such n exists.
- R8: When acknowledge c is high with level L, the pending and force bits of source L are both cleared at that clock edge.
- R9: If a rising edge on source L arrives in the same cycle as an acknowledge of L, pending bit L stays set.
- R10: Bit 0 of every register reads zero. Source input 0 and written bit 0 have no effect.
- R11: Reading 0x04 returns the pending bits, with bit n showing whether source n is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 16 | Source lines, bit n is source n (bit 0 unused) |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address of the word register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while busSel is high and busWr is low |
| ackValid | input | NCPU | Acknowledge strobe, one per processor |
| ackLevel | input | 4*NCPU | Acknowledged level, 4 bits per processor |
| reqLevel | output | 4*NCPU | Request level, 4 bits per processor |

## Verification
The hardest case to reach is a new rising edge on a source in exactly the cycle in which a processor acknowledges that same source. The port has to have fallen earlier, so that an edge is possible at all, and the acknowledge has to be lined up on the very same clock edge. The bench first latches the source and lets its line return low. It then checks that the level shows the source, and in one cycle it raises the line again and drives the acknowledge with that level. After that edge it reads pending back to confirm the bit survived.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int SRC_W = 16;          // bit 0 reserved, sources 1..15
  localparam int IDX_W = 4;           // processor index field width

  typedef enum logic [1:0] {RD_NONE, RD_PEND, RD_FORCE, RD_MASK} rdSel_e;

  typedef struct packed {
    logic             wrForce;
    logic             wrClear;
    logic             wrMask;
    logic [IDX_W-1:0] maskIdx;
    rdSel_e           rdSel;
    logic [SRC_W-1:0] wdata;
  } strobe_t;
endpackage

// File: rtl/irq_ctrl_decode.sv
module irq_ctrl_decode
  import irq_ctrl_pkg::*;
#(
  parameter int NCPU       = 2,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int PEND_ADDR  = 'h04,
  parameter int FORCE_ADDR = 'h08,
  parameter int CLEAR_ADDR = 'h0C,
  parameter int MASK_BASE  = 'h40
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output strobe_t           strb
);
  localparam logic [ADDR_W-1:0] PEND_A  = ADDR_W'(PEND_ADDR);
  localparam logic [ADDR_W-1:0] FORCE_A = ADDR_W'(FORCE_ADDR);
  localparam logic [ADDR_W-1:0] CLEAR_A = ADDR_W'(CLEAR_ADDR);
  localparam logic [ADDR_W-1:0] MASK_A  = ADDR_W'(MASK_BASE);
  localparam logic [ADDR_W-1:0] MASK_SPAN = ADDR_W'(4 * NCPU);

  logic [ADDR_W-1:0] maskOfs;
  logic              maskHit;

  assign maskOfs = busAddr - MASK_A;
  assign maskHit = (busAddr >= MASK_A) && (maskOfs < MASK_SPAN) && (maskOfs[1:0] == 2'b00);

  always_comb begin
    strb         = '0;
    strb.rdSel   = RD_NONE;
    strb.wdata   = busWdata[SRC_W-1:0];
    strb.maskIdx = maskOfs[IDX_W+1:2];
    if (busSel) begin
      if (busWr) begin
        strb.wrForce = (busAddr == FORCE_A);
        strb.wrClear = (busAddr == CLEAR_A);
        strb.wrMask  = maskHit;
      end else begin
        if (busAddr == PEND_A)       strb.rdSel = RD_PEND;
        else if (busAddr == FORCE_A) strb.rdSel = RD_FORCE;
        else if (maskHit)            strb.rdSel = RD_MASK;
      end
    end
  end
endmodule

// File: rtl/irq_ctrl_prio.sv
module irq_ctrl_prio #(
  parameter int SRC_W = 16,
  parameter int LVL_W = 4
) (
  input  logic [SRC_W-1:0] active,
  output logic [LVL_W-1:0] level
);
  always_comb begin
    level = '0;
    for (int i = 1; i < SRC_W; i++) begin
      if (active[i]) level = LVL_W'(i);
    end
  end

  always_comb begin
    if (level != '0) assert (active[level]) else $error("AST_LEVEL_ACTIVE"); // R7
  end
endmodule

// File: rtl/irq_ctrl_state.sv
module irq_ctrl_state
  import irq_ctrl_pkg::*;
#(
  parameter int NCPU   = 2,
  parameter int DATA_W = 32,
  parameter int LVL_W  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [SRC_W-1:0]      srcIn,
  input  strobe_t               strb,
  input  logic [NCPU-1:0]       ackValid,
  input  logic [NCPU*LVL_W-1:0] ackLevel,
  output logic [DATA_W-1:0]     rdData,
  output logic [NCPU*LVL_W-1:0] reqLevel
);
  localparam logic [SRC_W-1:0] VALID = {{(SRC_W-1){1'b1}}, 1'b0};

  logic [SRC_W-1:0] srcPrev, pending, forceReg;
  logic [SRC_W-1:0] maskReg [NCPU];
  logic [SRC_W-1:0] rise, wrBits, ackClr, clrAll;
  logic             armed;

  assign rise   = srcIn & ~srcPrev & VALID;
  assign wrBits = strb.wdata & VALID;

  always_comb begin
    ackClr = '0;
    for (int c = 0; c < NCPU; c++) begin
      if (ackValid[c]) ackClr[ackLevel[c*LVL_W +: LVL_W]] = 1'b1;
    end
    ackClr = ackClr & VALID;
    clrAll = ackClr | (strb.wrClear ? wrBits : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPrev  <= '0;
      pending  <= '0;
      forceReg <= '0;
      armed    <= 1'b0;
    end else begin
      srcPrev  <= srcIn;
      pending  <= (pending & ~clrAll) | rise;
      forceReg <= (forceReg & ~clrAll) | (strb.wrForce ? wrBits : '0);
      armed    <= 1'b1;
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [SRC_W-1:0] active;
    always_ff @(posedge clk) begin
      if (!rstN) maskReg[c] <= '0;
      else if (strb.wrMask && strb.maskIdx == IDX_W'(c)) maskReg[c] <= wrBits;
    end
    assign active = (pending | forceReg) & maskReg[c];
    irq_ctrl_prio #(.SRC_W(SRC_W), .LVL_W(LVL_W)) u_prio (
      .active(active),
      .level (reqLevel[c*LVL_W +: LVL_W])
    );
  end

  always_comb begin
    rdData = '0;
    case (strb.rdSel)
      RD_PEND:  rdData = DATA_W'(pending);
      RD_FORCE: rdData = DATA_W'(forceReg);
      RD_MASK: begin
        for (int c = 0; c < NCPU; c++) begin
          if (strb.maskIdx == IDX_W'(c)) rdData = DATA_W'(maskReg[c]);
        end
      end
      default:  rdData = '0;
    endcase
  end

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> ((pending & $past(rise)) == $past(rise))); // R2
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (($past(pending) & ~pending & ~$past(clrAll)) == '0)); // R3
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(strb.wrClear)) |-> ((forceReg & $past(wrBits)) == '0)); // R4
  AST_FORCE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(strb.wrForce)) |-> ((forceReg & $past(wrBits)) == $past(wrBits))); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> ((pending & $past(ackClr) & ~$past(rise)) == '0)); // R8
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NCPU   = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LVL_W  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [SRC_W-1:0]      srcIn,
  input  logic                  busSel,
  input  logic                  busWr,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic [NCPU-1:0]       ackValid,
  input  logic [NCPU*LVL_W-1:0] ackLevel,
  output logic [NCPU*LVL_W-1:0] reqLevel
);
  strobe_t strb;

  irq_ctrl_decode #(.NCPU(NCPU), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .strb    (strb)
  );

  irq_ctrl_state #(.NCPU(NCPU), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_state (
    .clk     (clk),
    .rstN    (rstN),
    .srcIn   (srcIn),
    .strb    (strb),
    .ackValid(ackValid),
    .ackLevel(ackLevel),
    .rdData  (busRdata),
    .reqLevel(reqLevel)
  );

  AST_RD_BIT0: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[0] == 1'b0); // R10
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] srcIn = '0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  ackValid = '0;
  logic [7:0]  ackLevel = '0;
  logic [7:0]  reqLevel;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .ackValid(ackValid), .ackLevel(ackLevel), .reqLevel(reqLevel)
  );

  // {wr, addr, wdata, expected read, expected level cpu0, expected level cpu1}
  localparam logic [80:0] VEC [0:13] = '{
    {1'b1, 8'h08, 32'h0000_0024, 32'h0,         4'd0,  4'd0},  // R5 force 2,5
    {1'b0, 8'h08, 32'h0,         32'h0000_0024, 4'd0,  4'd0},  // R5 readback
    {1'b1, 8'h40, 32'h0000_FFFE, 32'h0,         4'd5,  4'd0},  // R6 R7
    {1'b1, 8'h44, 32'h0000_0004, 32'h0,         4'd5,  4'd2},  // R6
    {1'b1, 8'h0C, 32'h0000_0020, 32'h0,         4'd2,  4'd2},  // R4
    {1'b0, 8'h08, 32'h0,         32'h0000_0004, 4'd2,  4'd2},  // R4
    {1'b1, 8'h08, 32'h0000_8001, 32'h0,         4'd15, 4'd2},  // R5 R7
    {1'b0, 8'h08, 32'h0,         32'h0000_8004, 4'd15, 4'd2},  // R10
    {1'b0, 8'h40, 32'h0,         32'h0000_FFFE, 4'd15, 4'd2},  // R6
    {1'b1, 8'h40, 32'h0000_0001, 32'h0,         4'd0,  4'd2},  // R10 R7
    {1'b0, 8'h40, 32'h0,         32'h0,         4'd0,  4'd2},  // R10
    {1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h0,         4'd0,  4'd0},  // R4
    {1'b0, 8'h08, 32'h0,         32'h0,         4'd0,  4'd0},  // R4
    {1'b0, 8'h04, 32'h0,         32'h0,         4'd0,  4'd0}   // R11
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    tick();
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 levels", {24'h0, reqLevel}, 32'h0);
    rdReg(8'h04, rd); chk("R1 pending", rd, 32'h0);
    rdReg(8'h08, rd); chk("R1 force", rd, 32'h0);
    rdReg(8'h44, rd); chk("R1 mask1", rd, 32'h0);

    for (int i = 0; i < 14; i++) begin
      logic [80:0] v;
      v = VEC[i];
      if (v[80]) wrReg(v[79:72], v[71:40]);
      else begin
        rdReg(v[79:72], rd);
        chk("R5/R6/R10/R11 table read", rd, v[39:8]);
      end
      chk("R7 table level cpu0", {28'h0, reqLevel[3:0]}, {28'h0, v[7:4]});
      chk("R7 table level cpu1", {28'h0, reqLevel[7:4]}, {28'h0, v[3:0]});
    end

    wrReg(8'h40, 32'hFFFE);
    wrReg(8'h44, 32'hFFFE);
    // R2 edge latches
    srcIn[3] = 1'b1; tick(); srcIn[3] = 1'b0;
    chk("R2 level cpu0", {28'h0, reqLevel[3:0]}, 32'd3);
    chk("R2 level cpu1", {28'h0, reqLevel[7:4]}, 32'd3);
    rdReg(8'h04, rd); chk("R11 pending read", rd, 32'h8);
    tick(); tick(); tick();
    rdReg(8'h04, rd); chk("R3 pending holds", rd, 32'h8);
    // R10 source 0 ignored
    srcIn[0] = 1'b1; tick(); srcIn[0] = 1'b0; tick();
    rdReg(8'h04, rd); chk("R10 source 0", rd, 32'h8);
    // R7 highest wins, R4 selective clear, R2 no re-latch while high
    srcIn[7] = 1'b1; tick();
    chk("R7 highest", {28'h0, reqLevel[3:0]}, 32'd7);
    wrReg(8'h0C, 32'h80);
    tick(); tick();
    rdReg(8'h04, rd); chk("R4 R2 clear while held high", rd, 32'h8);
    srcIn[7] = 1'b0;
    // R8 ack clears pending
    ackValid = 2'b01; ackLevel = 8'h03; tick(); ackValid = '0;
    rdReg(8'h04, rd); chk("R8 ack pending", rd, 32'h0);
    chk("R8 level after ack", {28'h0, reqLevel[3:0]}, 32'd0);
    // R8 ack clears force
    wrReg(8'h08, 32'h200);
    chk("R5 forced level cpu1", {28'h0, reqLevel[7:4]}, 32'd9);
    ackValid = 2'b10; ackLevel = 8'h90; tick(); ackValid = '0;
    rdReg(8'h08, rd); chk("R8 ack force", rd, 32'h0);
    chk("R8 level cpu1", {28'h0, reqLevel[7:4]}, 32'd0);
    // R9 edge during ack wins
    srcIn[6] = 1'b1; tick(); srcIn[6] = 1'b0; tick();
    chk("R9 setup level", {28'h0, reqLevel[3:0]}, 32'd6);
    srcIn[6] = 1'b1; ackValid = 2'b01; ackLevel = 8'h06; tick();
    ackValid = '0;
    rdReg(8'h04, rd); chk("R9 pending survives", rd, 32'h40);
    chk("R9 level", {28'h0, reqLevel[3:0]}, 32'd6);
    srcIn[6] = 1'b0;
    // R6 per-processor mask
    wrReg(8'h44, 32'h0);
    chk("R6 cpu0 unchanged", {28'h0, reqLevel[3:0]}, 32'd6);
    chk("R6 cpu1 masked", {28'h0, reqLevel[7:4]}, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule